// File: doc/BRIEF.md
# Flash Command Interface and Status Register

This block is the command front end of a two-bank NOR flash. Every bus write cycle is decoded here. A write either selects what a read returns (array data, identifier codes, the status byte or a block's lock state), clears the status byte, or sets up an alteration. An alteration is a word program, a block erase, a lock-bit program or an erase of all unlocked blocks, and it needs a second write to complete it. When a sequence completes, the block sends a one-cycle start request, with the operation kind, address and data, to an external write state machine. It then reports busy in the status byte until that machine returns a done pulse and its error flags.

The block keeps the error flags until software clears them, and it shows the status byte by itself once an operation begins. A running operation can be suspended and later resumed, provided the bank address is correct. The block refuses to start a program or erase on a locked block while write protection is active. While an operation runs, reads aimed at the other bank return array data, so code can still execute from that bank.

Top module: `flash_cui`

## Requirements
- R1: While `rst_n` is low, any running operation is dropped. After reset the read path returns `arr_data`, and the status byte reads 80h.
- R2: Command byte FFh selects array reads, 90h selects identifier reads, 70h selects status reads and 71h selects lock reads. A lock read returns `blk_lock` on data bit 6, and every other bit is 0. In status reads the byte is {ready(7), suspended(6), erase error(5), program error(4), over-program(3), 000}, with zeros in the upper byte. The upper data byte of a command write is ignored.
- R3: In identifier mode, `rd_addr[0]`=0 returns 001Ch. `rd_addr[0]`=1 returns 00A1h for bottom boot (`TOP_BOOT`=0) and 00A0h for top boot.
- R4: The sequences 40h+address/data, 20h+D0h, 77h+D0h and A7h+D0h raise `op_start` for exactly the one cycle after the completing write. `op_kind` is 0, 1, 2 or 3 respectively, and `op_addr`/`op_data` carry the completing write's address and data.
- R5: From `op_start` until `wsm_done`, status mode is forced and bit 7 reads 0. On `wsm_done`, bit 7 returns to 1 and `wsm_err` {erase, program, over-program} is ORed into bits 5, 4 and 3.
- R6: Bits 5, 4 and 3 stay set through every command, including FFh, and only 50h issued while idle clears them.
- R7: B0h written while busy, with an address in the running operation's bank, pulses `op_suspend`, after which the status reads C0h. D0h written while suspended, in the same bank, pulses `op_resume` and returns the block to busy. Either command with the other bank's address is ignored.
- R8: If `wp1_n` or `wp2_n` is low and `blk_lock` is 0 on the completing write of a word program or block erase, no start is issued and the status reads B0h.
- R9: With both write-protect inputs high, a program or erase starts whatever the value of `blk_lock`.
- R10: An unknown first command, or a non-D0h byte where a confirm is expected, sets bits 5 and 4, selects status reads and issues no start.
- R11: A word program whose data write addresses bank II (addresses at or above 20000h with the defaults) is treated as a sequence error: bits 5 and 4 are set and no start is issued.
- R12: While busy, only 70h and B0h have an effect, and all other writes leave the reads and outputs unchanged. While suspended, the read-mode commands FFh, 90h, 70h and 71h are accepted.
- R13: While busy, a read whose `rd_addr` lies in the other bank returns `arr_data`. A read in the busy bank returns the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; aborts all activity |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; the low byte carries the command |
| rd_addr | input | AW | Current read address |
| rd_data | output | DW | Read data for the selected mode |
| arr_data | input | DW | Array word at `rd_addr` |
| blk_lock | input | 1 | Lock bit of the addressed block (1 = unlocked) |
| wp1_n | input | 1 | Write protect, active low |
| wp2_n | input | 1 | Write protect, active low |
| op_start | output | 1 | Start request to the write state machine |
| op_kind | output | 2 | 0 program, 1 erase, 2 lock set, 3 erase all |
| op_addr | output | AW | Target address of the operation |
| op_data | output | DW | Program data |
| op_suspend | output | 1 | Suspend request pulse |
| op_resume | output | 1 | Resume request pulse |
| wsm_done | input | 1 | Operation finished pulse |
| wsm_err | input | 3 | {erase error, program error, over-program} at done |

## Verification
The hardest state to reach is a suspended erase with array reads selected and a resume written with the wrong bank. The bench reaches it by starting an erase in bank II and writing B0h first to bank I, which must be ignored, and then to bank II. It then writes FFh, writes D0h to bank I, which must be ignored, and finally writes D0h to bank II. Throughout this sequence the bench moves `rd_addr` between the banks, so the read path during the background operation is checked cycle by cycle against the reference model.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2,
        RM_LOCK   = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_PROG_DATA = 3'd1,
        PH_CONFIRM   = 3'd2,
        PH_BUSY      = 3'd3,
        PH_SUSP      = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        OP_PROG      = 2'd0,
        OP_ERASE     = 2'd1,
        OP_LOCKSET   = 2'd2,
        OP_ERASE_ALL = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        C_READ_ARRAY,
        C_READ_ID,
        C_READ_SR,
        C_READ_LOCK,
        C_CLR_SR,
        C_PROG,
        C_ERASE,
        C_LOCKSET,
        C_ERASE_ALL,
        C_SUSPEND,
        C_CONFIRM,
        C_BAD
    } cmd_e;

    localparam logic [7:0] ID_MAKER     = 8'h1C;
    localparam logic [7:0] ID_DEV_TOP   = 8'hA0;
    localparam logic [7:0] ID_DEV_BOT   = 8'hA1;
    localparam logic [2:0] SEQ_ERR_BITS = 3'b110;

endpackage

// File: rtl/flash_cui_decode.sv
module flash_cui_decode
    import flash_cui_pkg::*;
(
    input  logic [7:0] code,
    output cmd_e       cmd
);
    always_comb begin
        unique case (code)
            8'hFF:   cmd = C_READ_ARRAY;
            8'h90:   cmd = C_READ_ID;
            8'h70:   cmd = C_READ_SR;
            8'h71:   cmd = C_READ_LOCK;
            8'h50:   cmd = C_CLR_SR;
            8'h40:   cmd = C_PROG;
            8'h20:   cmd = C_ERASE;
            8'h77:   cmd = C_LOCKSET;
            8'hA7:   cmd = C_ERASE_ALL;
            8'hB0:   cmd = C_SUSPEND;
            8'hD0:   cmd = C_CONFIRM;
            default: cmd = C_BAD;
        endcase
    end
endmodule

// File: rtl/flash_cui_bank.sv
module flash_cui_bank #(
    parameter int AW          = 20,
    parameter int BANK1_WORDS = 32'h20000,
    parameter bit TOP_BOOT    = 1'b0
) (
    input  logic [AW-1:0] addr,
    output logic          in_bank1
);
    localparam logic [AW:0] LIM_LO = (AW+1)'(BANK1_WORDS);
    localparam logic [AW:0] LIM_HI = (AW+1)'((64'd1 << AW) - 64'(BANK1_WORDS));

    generate
        if (TOP_BOOT) begin : g_top
            assign in_bank1 = ({1'b0, addr} >= LIM_HI);
        end else begin : g_bottom
            assign in_bank1 = ({1'b0, addr} < LIM_LO);
        end
    endgenerate
endmodule

// File: rtl/flash_cui_rdmux.sv
module flash_cui_rdmux
    import flash_cui_pkg::*;
#(
    parameter int DW       = 16,
    parameter bit TOP_BOOT = 1'b0
) (
    input  rmode_e          mode,
    input  logic            addr_lsb,
    input  logic [7:0]      status,
    input  logic            lock_bit,
    input  logic [DW-1:0]   arr_data,
    output logic [DW-1:0]   rd_data
);
    localparam int         LOCK_POS = 6;
    localparam logic [7:0] DEV_CODE = TOP_BOOT ? ID_DEV_TOP : ID_DEV_BOT;

    always_comb begin
        rd_data = '0;
        unique case (mode)
            RM_ARRAY:  rd_data = arr_data;
            RM_IDENT:  rd_data[7:0] = addr_lsb ? DEV_CODE : ID_MAKER;
            RM_STATUS: rd_data[7:0] = status;
            RM_LOCK:   rd_data[LOCK_POS] = lock_bit;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/flash_cui.sv
module flash_cui
    import flash_cui_pkg::*;
#(
    parameter int AW          = 20,
    parameter int DW          = 16,
    parameter int BANK1_WORDS = 32'h20000,
    parameter bit TOP_BOOT    = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic [DW-1:0] arr_data,
    input  logic          blk_lock,
    input  logic          wp1_n,
    input  logic          wp2_n,
    output logic          op_start,
    output logic [1:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic          op_suspend,
    output logic          op_resume,
    input  logic          wsm_done,
    input  logic [2:0]    wsm_err
);
    typedef struct packed {
        rmode_e        mode;
        phase_e        ph;
        op_e           kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          bank1;
        logic [2:0]    sticky;
        logic          start;
        logic          susp;
        logic          resume;
    } cui_state_t;

    cui_state_t q, d;
    cmd_e       cmd;
    logic       wr_bank1;
    logic       rd_bank1;
    logic       blocked;
    logic [7:0] sr;
    rmode_e     eff_mode;

    flash_cui_decode i_decode (
        .code (wr_data[7:0]),
        .cmd  (cmd)
    );

    flash_cui_bank #(.AW(AW), .BANK1_WORDS(BANK1_WORDS), .TOP_BOOT(TOP_BOOT)) i_wr_bank (
        .addr     (wr_addr),
        .in_bank1 (wr_bank1)
    );

    flash_cui_bank #(.AW(AW), .BANK1_WORDS(BANK1_WORDS), .TOP_BOOT(TOP_BOOT)) i_rd_bank (
        .addr     (rd_addr),
        .in_bank1 (rd_bank1)
    );

    assign blocked = (!wp1_n || !wp2_n) && !blk_lock;
    assign sr      = {q.ph != PH_BUSY, q.ph == PH_SUSP, q.sticky, 3'b000};

    // Reads aimed at the idle bank bypass status while an operation runs
    assign eff_mode = (q.ph == PH_BUSY && rd_bank1 != q.bank1) ? RM_ARRAY : q.mode;

    flash_cui_rdmux #(.DW(DW), .TOP_BOOT(TOP_BOOT)) i_rdmux (
        .mode     (eff_mode),
        .addr_lsb (rd_addr[0]),
        .status   (sr),
        .lock_bit (blk_lock),
        .arr_data (arr_data),
        .rd_data  (rd_data)
    );

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        d.susp   = 1'b0;
        d.resume = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (wr_en) begin
                    unique case (cmd)
                        C_READ_ARRAY: d.mode = RM_ARRAY;
                        C_READ_ID:    d.mode = RM_IDENT;
                        C_READ_SR:    d.mode = RM_STATUS;
                        C_READ_LOCK:  d.mode = RM_LOCK;
                        C_CLR_SR:     d.sticky = '0;
                        C_PROG: begin
                            d.ph   = PH_PROG_DATA;
                            d.mode = RM_STATUS;
                        end
                        C_ERASE, C_LOCKSET, C_ERASE_ALL: begin
                            d.ph   = PH_CONFIRM;
                            d.mode = RM_STATUS;
                            d.kind = (cmd == C_ERASE)   ? OP_ERASE :
                                     (cmd == C_LOCKSET) ? OP_LOCKSET : OP_ERASE_ALL;
                        end
                        C_SUSPEND:    d.mode = RM_STATUS;
                        default: begin
                            d.sticky = q.sticky | SEQ_ERR_BITS;
                            d.mode   = RM_STATUS;
                        end
                    endcase
                end
            end
            PH_PROG_DATA: begin
                if (wr_en) begin
                    d.mode = RM_STATUS;
                    if (!wr_bank1 || blocked) begin
                        d.ph     = PH_IDLE;
                        d.sticky = q.sticky | SEQ_ERR_BITS;
                    end else begin
                        d.ph    = PH_BUSY;
                        d.kind  = OP_PROG;
                        d.addr  = wr_addr;
                        d.data  = wr_data;
                        d.bank1 = 1'b1;
                        d.start = 1'b1;
                    end
                end
            end
            PH_CONFIRM: begin
                if (wr_en) begin
                    d.mode = RM_STATUS;
                    if (cmd != C_CONFIRM || (q.kind == OP_ERASE && blocked)) begin
                        d.ph     = PH_IDLE;
                        d.sticky = q.sticky | SEQ_ERR_BITS;
                    end else begin
                        d.ph    = PH_BUSY;
                        d.addr  = wr_addr;
                        d.data  = wr_data;
                        d.bank1 = wr_bank1;
                        d.start = 1'b1;
                    end
                end
            end
            PH_BUSY: begin
                if (wsm_done) begin
                    d.ph     = PH_IDLE;
                    d.sticky = q.sticky | wsm_err;
                end else if (wr_en) begin
                    if (cmd == C_READ_SR) begin
                        d.mode = RM_STATUS;
                    end else if (cmd == C_SUSPEND && wr_bank1 == q.bank1) begin
                        d.ph   = PH_SUSP;
                        d.susp = 1'b1;
                        d.mode = RM_STATUS;
                    end
                end
            end
            PH_SUSP: begin
                if (wr_en) begin
                    unique case (cmd)
                        C_READ_ARRAY: d.mode = RM_ARRAY;
                        C_READ_ID:    d.mode = RM_IDENT;
                        C_READ_SR:    d.mode = RM_STATUS;
                        C_READ_LOCK:  d.mode = RM_LOCK;
                        C_CONFIRM: begin
                            if (wr_bank1 == q.bank1) begin
                                d.ph     = PH_BUSY;
                                d.resume = 1'b1;
                                d.mode   = RM_STATUS;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mode: RM_ARRAY, ph: PH_IDLE, kind: OP_PROG, addr: '0, data: '0,
                   bank1: 1'b0, sticky: '0, start: 1'b0, susp: 1'b0, resume: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign op_start   = q.start;
    assign op_kind    = q.kind;
    assign op_addr    = q.addr;
    assign op_data    = q.data;
    assign op_suspend = q.susp;
    assign op_resume  = q.resume;

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);  // R4

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> (sr[7] == 1'b0 && q.mode == RM_STATUS));  // R5

    AST_SUSPEND_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        op_suspend |-> (sr[7:6] == 2'b11));  // R7

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && cmd == C_CLR_SR) |=> ((q.sticky & $past(q.sticky)) == $past(q.sticky)));  // R6

    AST_LOCKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.ph == PH_PROG_DATA && blocked) |=> !op_start);  // R8

endmodule

// File: tb/test_flash_cui.sv
`timescale 1ns/1ps
module test_flash_cui;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [19:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] arr_data = 16'h5A5A;
    logic        blk_lock = 1'b1;
    logic        wp1_n = 1'b1;
    logic        wp2_n = 1'b1;
    logic        op_start;
    logic [1:0]  op_kind;
    logic [19:0] op_addr;
    logic [15:0] op_data;
    logic        op_suspend;
    logic        op_resume;
    logic        wsm_done = 1'b0;
    logic [2:0]  wsm_err = '0;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";
    bit    finished = 1'b0;

    always #2 clk = ~clk;

    flash_cui i_flash_cui (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .arr_data(arr_data), .blk_lock(blk_lock),
        .wp1_n(wp1_n), .wp2_n(wp2_n), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .op_suspend(op_suspend),
        .op_resume(op_resume), .wsm_done(wsm_done), .wsm_err(wsm_err)
    );

    // ---------------- behavioural reference model ----------------
    int         m_mode;   // 0 array, 1 ident, 2 status, 3 lock
    int         m_ph;     // 0 idle, 1 await data, 2 await confirm, 3 busy, 4 suspended
    int         m_kind;
    logic [7:0] m_sticky;
    logic [19:0] m_addr;
    logic [15:0] m_data;
    bit         m_bank1, m_start, m_susp, m_res;

    function automatic bit in_b1(input logic [19:0] a);
        return a < 20'h20000;
    endfunction

    function automatic logic [15:0] model_rd();
        logic [7:0] s;
        int         md;
        s = m_sticky;
        if (m_ph != 3) s = s | 8'h80;
        if (m_ph == 4) s = s | 8'h40;
        md = m_mode;
        if (m_ph == 3 && in_b1(rd_addr) != m_bank1) md = 0;
        case (md)
            0: return arr_data;
            1: return rd_addr[0] ? 16'h00A1 : 16'h001C;
            2: return {8'h00, s};
            default: return blk_lock ? 16'h0040 : 16'h0000;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_ph = 0; m_kind = 0; m_sticky = 0; m_addr = 0; m_data = 0;
            m_bank1 = 0; m_start = 0; m_susp = 0; m_res = 0;
        end else begin
            logic [7:0] c;
            bit         prot;
            c = wr_data[7:0];
            prot = !wp1_n || !wp2_n;
            m_start = 0; m_susp = 0; m_res = 0;
            if (m_ph == 3 && wsm_done) begin
                m_ph = 0;
                m_sticky = m_sticky | {2'b00, wsm_err, 3'b000};
            end else if (wr_en) begin
                if (m_ph == 0) begin
                    case (c)
                        8'hFF: m_mode = 0;
                        8'h90: m_mode = 1;
                        8'h70: m_mode = 2;
                        8'h71: m_mode = 3;
                        8'h50: m_sticky = 0;
                        8'h40: begin m_ph = 1; m_mode = 2; end
                        8'h20: begin m_ph = 2; m_kind = 1; m_mode = 2; end
                        8'h77: begin m_ph = 2; m_kind = 2; m_mode = 2; end
                        8'hA7: begin m_ph = 2; m_kind = 3; m_mode = 2; end
                        8'hB0: m_mode = 2;
                        default: begin m_sticky = m_sticky | 8'h30; m_mode = 2; end
                    endcase
                end else if (m_ph == 1) begin
                    m_mode = 2;
                    if (!in_b1(wr_addr) || (prot && !blk_lock)) begin
                        m_ph = 0; m_sticky = m_sticky | 8'h30;
                    end else begin
                        m_ph = 3; m_kind = 0; m_addr = wr_addr; m_data = wr_data;
                        m_bank1 = 1; m_start = 1;
                    end
                end else if (m_ph == 2) begin
                    m_mode = 2;
                    if (c != 8'hD0 || (m_kind == 1 && prot && !blk_lock)) begin
                        m_ph = 0; m_sticky = m_sticky | 8'h30;
                    end else begin
                        m_ph = 3; m_addr = wr_addr; m_data = wr_data;
                        m_bank1 = in_b1(wr_addr); m_start = 1;
                    end
                end else if (m_ph == 3) begin
                    if (c == 8'h70) m_mode = 2;
                    else if (c == 8'hB0 && in_b1(wr_addr) == m_bank1) begin
                        m_ph = 4; m_susp = 1; m_mode = 2;
                    end
                end else begin
                    case (c)
                        8'hFF: m_mode = 0;
                        8'h90: m_mode = 1;
                        8'h70: m_mode = 2;
                        8'h71: m_mode = 3;
                        8'hD0: if (in_b1(wr_addr) == m_bank1) begin
                            m_ph = 3; m_res = 1; m_mode = 2;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            check(cur_req, rd_data === model_rd(), 32'(rd_data), 32'(model_rd()));
            check(cur_req, op_start === m_start, 32'(op_start), 32'(m_start));
            check(cur_req, op_suspend === m_susp, 32'(op_suspend), 32'(m_susp));
            check(cur_req, op_resume === m_res, 32'(op_resume), 32'(m_res));
            if (m_start) begin
                check(cur_req, op_kind === 2'(m_kind), 32'(op_kind), 32'(m_kind));
                check(cur_req, op_addr === m_addr, 32'(op_addr), 32'(m_addr));
                check(cur_req, op_data === m_data, 32'(op_data), 32'(m_data));
            end
        end
    end

    task automatic wr(input logic [19:0] a, input logic [15:0] dt);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = dt;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic done(input logic [2:0] e);
        @(posedge clk); #1;
        wsm_done = 1'b1; wsm_err = e;
        @(posedge clk); #1;
        wsm_done = 1'b0; wsm_err = '0;
    endtask

    task automatic expect_rd(input string req, input logic [15:0] exp);
        @(negedge clk);
        check(req, rd_data === exp, 32'(rd_data), 32'(exp));
    endtask

    task automatic expect_start(input string req, input bit exp);
        @(negedge clk);
        check(req, op_start === exp, 32'(op_start), 32'(exp));
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #400000;
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R1";
        expect_rd("R1", 16'h5A5A);
        wr(20'h0, 16'h0070);
        expect_rd("R1", 16'h0080);

        cur_req = "R3";
        wr(20'h0, 16'hAB90);      // upper byte ignored (R2)
        rd_addr = 20'h0;
        expect_rd("R3", 16'h001C);
        rd_addr = 20'h1;
        expect_rd("R3", 16'h00A1);

        cur_req = "R2";
        wr(20'h0, 16'h0071);
        blk_lock = 1'b1;
        expect_rd("R2", 16'h0040);
        blk_lock = 1'b0;
        expect_rd("R2", 16'h0000);
        blk_lock = 1'b1;
        wr(20'h0, 16'h00FF);
        expect_rd("R2", 16'h5A5A);

        cur_req = "R4";
        wr(20'h00000, 16'h0040);
        wr(20'h01234, 16'hBEEF);
        @(negedge clk);
        check("R4", op_start === 1'b1 && op_kind === 2'd0, 32'({op_start, op_kind}), 32'h4);
        check("R4", op_data === 16'hBEEF, 32'(op_data), 32'hBEEF);
        cur_req = "R5";
        rd_addr = 20'h00010;
        expect_rd("R5", 16'h0000);
        done(3'b000);
        expect_rd("R5", 16'h0080);

        cur_req = "R10";
        wr(20'h0, 16'h0012);
        expect_rd("R10", 16'h00B0);
        cur_req = "R6";
        wr(20'h0, 16'h00FF);
        wr(20'h0, 16'h0070);
        expect_rd("R6", 16'h00B0);
        wr(20'h0, 16'h0050);
        expect_rd("R6", 16'h0080);

        cur_req = "R11";
        wr(20'h0, 16'h0040);
        wr(20'h40000, 16'h1111);
        expect_start("R11", 1'b0);
        expect_rd("R11", 16'h00B0);
        wr(20'h0, 16'h0050);

        cur_req = "R7";
        wr(20'h50000, 16'h0020);
        wr(20'h50000, 16'h00D0);
        rd_addr = 20'h50000;
        wr(20'h00010, 16'h00B0);  // wrong bank, ignored
        expect_rd("R7", 16'h0000);
        wr(20'h50000, 16'h00B0);
        expect_rd("R7", 16'h00C0);
        wr(20'h0, 16'h00FF);
        expect_rd("R12", 16'h5A5A);
        wr(20'h00010, 16'h00D0);  // wrong bank, ignored
        expect_rd("R7", 16'h5A5A);
        wr(20'h50000, 16'h00D0);
        expect_rd("R7", 16'h0000);
        cur_req = "R13";
        rd_addr = 20'h00005;
        arr_data = 16'h1357;
        expect_rd("R13", 16'h1357);
        rd_addr = 20'h50004;
        expect_rd("R13", 16'h0000);
        cur_req = "R12";
        wr(20'h0, 16'h00FF);
        wr(20'h0, 16'h0020);
        expect_start("R12", 1'b0);
        expect_rd("R12", 16'h0000);
        cur_req = "R5";
        done(3'b100);
        expect_rd("R5", 16'h00A0);
        wr(20'h0, 16'h0050);

        cur_req = "R8";
        wp1_n = 1'b0; blk_lock = 1'b0;
        wr(20'h60000, 16'h0020);
        wr(20'h60000, 16'h00D0);
        expect_start("R8", 1'b0);
        expect_rd("R8", 16'h00B0);
        wr(20'h0, 16'h0050);
        wp1_n = 1'b1; wp2_n = 1'b0;
        wr(20'h0, 16'h0040);
        wr(20'h00100, 16'h2222);
        expect_start("R8", 1'b0);
        expect_rd("R8", 16'h00B0);
        wr(20'h0, 16'h0050);

        cur_req = "R9";
        wp2_n = 1'b1;
        wr(20'h60000, 16'h0020);
        wr(20'h60000, 16'h00D0);
        expect_start("R9", 1'b1);
        done(3'b000);
        blk_lock = 1'b1;

        cur_req = "R10";
        wr(20'h0, 16'h0077);
        wr(20'h0, 16'h0033);
        expect_start("R10", 1'b0);
        expect_rd("R10", 16'h00B0);
        wr(20'h0, 16'h0050);
        cur_req = "R4";
        wr(20'h08000, 16'h0077);
        wr(20'h08000, 16'h00D0);
        @(negedge clk);
        check("R4", op_kind === 2'd2, 32'(op_kind), 32'd2);
        done(3'b000);
        wr(20'h0, 16'h00A7);
        wr(20'h0, 16'h00D0);
        @(negedge clk);
        check("R4", op_kind === 2'd3, 32'(op_kind), 32'd3);
        cur_req = "R5";
        done(3'b001);
        expect_rd("R5", 16'h0088);
        wr(20'h0, 16'h0050);

        cur_req = "R1";
        wr(20'h70000, 16'h0020);
        wr(20'h70000, 16'h00D0);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        rd_addr = 20'h70000;
        expect_rd("R1", 16'h1357);
        wr(20'h0, 16'h0070);
        expect_rd("R1", 16'h0080);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule